// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block forms the memory address for one load or store in a 64-bit pipeline. It is purely combinational, so the result is available in the same cycle as the operands. It takes a base value, flags that say whether the base is the stack pointer or the program counter, an offset source and an indexing mode. The offset is either a raw immediate field decoded in one of three formats, a 64-bit index, or a 32-bit index that is sign- or zero-extended. The unit returns the effective address, the value to write back to the base register for pre- and post-indexed forms, a stack alignment fault and an illegal-combination flag.

Offsets are two's complement and are added to the base with 64-bit wraparound. There is no subtract mode: a negative immediate or a negative index moves the address downward. The decode that produces the selects, the register file and the memory access itself are outside this block.

Top module: `lsu_addr_gen`

## Requirements
- R1: With offset source none (`offSrc`=0) and indexing mode plain offset (`idxMode`=0), the address equals the base.
- R2: With offset source immediate (`offSrc`=1), `immFmt`=0 takes `immRaw[6:0]` as a signed value shifted left by `sizeLog2`. `immFmt`=1 takes `immRaw[8:0]` as a signed value with no shift. `immFmt`=2 takes `immRaw[11:0]` as an unsigned value shifted left by `sizeLog2`.
- R3: In pre-indexed mode (`idxMode`=1), the address and the writeback value both equal base plus offset, and `wbEn` is 1 when no flag is raised.
- R4: In post-indexed mode (`idxMode`=2), the address equals the unmodified base and the writeback value equals base plus offset.
- R5: With offset source register (`offSrc`=2), the offset is the 64-bit `index`. It is shifted left by `sizeLog2` when `scaleEn` is 1 and is used unshifted otherwise.
- R6: With offset source extended register (`offSrc`=3), `index[31:0]` is sign-extended when `extSigned` is 1 and zero-extended when it is 0. The result is then shifted as in R5.
- R7: In literal mode (`idxMode`=3), the decoded immediate is always shifted left by 2, whatever the format and the access size. A `sizeLog2` of 0 or 1 in literal mode raises `illegal`.
- R8: `illegal` is raised for each of these: pre- or post-indexing with an offset source other than immediate; pre- or post-indexing with `immFmt`=2; an immediate source with `immFmt`=3; literal mode with an offset source other than immediate.
- R9: `illegal` is raised when `baseIsPc` is 1 outside literal mode, and when literal mode is used with `baseIsPc` at 0.
- R10: `spFault` is raised exactly when `baseIsSp` is 1 and `base[3:0]` is not zero, in every mode.
- R11: `wbEn` is 1 only in pre- or post-indexed mode, and only when both `spFault` and `illegal` are 0.
- R12: All additions wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base | input | 64 | Base register value |
| baseIsSp | input | 1 | Base is the stack pointer |
| baseIsPc | input | 1 | Base is the program counter |
| offSrc | input | 2 | Offset source: 0 none, 1 immediate, 2 register, 3 extended register |
| idxMode | input | 2 | Indexing: 0 offset, 1 pre, 2 post, 3 literal |
| immFmt | input | 2 | Immediate format: 0 signed 7-bit scaled, 1 signed 9-bit unscaled, 2 unsigned 12-bit scaled, 3 reserved |
| immRaw | input | 12 | Raw immediate field |
| index | input | 64 | Index register value |
| scaleEn | input | 1 | Shift the index by the access size |
| extSigned | input | 1 | Sign-extend (1) or zero-extend (0) the 32-bit index |
| sizeLog2 | input | 2 | log2 of the access size in bytes |
| addr | output | 64 | Effective memory address |
| wbEn | output | 1 | Write the base register back |
| wbVal | output | 64 | Writeback value |
| spFault | output | 1 | Misaligned stack pointer base |
| illegal | output | 1 | Illegal combination of selects |

## Verification
The stack alignment check and base writeback can apply to the same operation. A pre- or post-indexed access through a misaligned stack pointer must raise the fault and suppress `wbEn`, while `wbVal` still carries the sum. The bench sets up this case on purpose with SP bases whose low bits are 8, and again with an illegal register-offset writeback on a misaligned SP, where both flags must rise together. A behavioural reference model written with signed integer arithmetic judges all five outputs for each directed vector and for a long run of random vectors.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;
  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_IMM = 2'd1, SRC_REG = 2'd2, SRC_EXT = 2'd3} offSrcE;
  typedef enum logic [1:0] {IDX_OFFSET = 2'd0, IDX_PRE = 2'd1, IDX_POST = 2'd2, IDX_LIT = 2'd3} idxModeE;
  typedef enum logic [1:0] {FMT_S7 = 2'd0, FMT_S9 = 2'd1, FMT_U12 = 2'd2, FMT_BAD = 2'd3} immFmtE;

  // strobes from control to datapath
  typedef struct packed {
    logic       useImm;
    logic       useIdx;
    logic       idxWide;
    logic       extSigned;
    immFmtE     fmt;
    logic [1:0] shiftAmt;
    logic       addrFromBase;
  } aguStrobeT;
endpackage

// File: rtl/lsu_agu_ctrl.sv
module lsu_agu_ctrl
  import lsu_agu_pkg::*;
#(
  parameter int ALIGN_BITS = 4
) (
  input  logic [ALIGN_BITS-1:0] baseLow,
  input  logic                  baseIsSp,
  input  logic                  baseIsPc,
  input  offSrcE                offSrc,
  input  idxModeE               idxMode,
  input  immFmtE                immFmt,
  input  logic                  scaleEn,
  input  logic                  extSigned,
  input  logic [1:0]            sizeLog2,
  output aguStrobeT             strobe,
  output logic                  wbEn,
  output logic                  spFault,
  output logic                  illegal
);
  localparam logic [1:0] LIT_SHIFT = 2'd2;

  logic isWb;
  logic isLit;
  logic badWb;
  logic badFmt;
  logic badLit;
  logic badPc;

  assign isWb  = (idxMode == IDX_PRE) || (idxMode == IDX_POST);
  assign isLit = (idxMode == IDX_LIT);

  always_comb begin
    strobe              = '0;
    strobe.useImm       = (offSrc == SRC_IMM);
    strobe.useIdx       = (offSrc == SRC_REG) || (offSrc == SRC_EXT);
    strobe.idxWide      = (offSrc == SRC_REG);
    strobe.extSigned    = extSigned;
    strobe.fmt          = immFmt;
    strobe.addrFromBase = (idxMode == IDX_POST);
    if (isLit) begin
      strobe.shiftAmt = LIT_SHIFT;
    end else if (strobe.useImm) begin
      strobe.shiftAmt = (immFmt == FMT_S9) ? 2'd0 : sizeLog2;
    end else if (strobe.useIdx) begin
      strobe.shiftAmt = scaleEn ? sizeLog2 : 2'd0;
    end else begin
      strobe.shiftAmt = 2'd0;
    end
  end

  assign badWb   = isWb && ((offSrc != SRC_IMM) || (immFmt == FMT_U12));
  assign badFmt  = (offSrc == SRC_IMM) && (immFmt == FMT_BAD);
  assign badLit  = isLit && ((offSrc != SRC_IMM) || (sizeLog2 < 2'd2) || !baseIsPc);
  assign badPc   = baseIsPc && !isLit;

  assign illegal = badWb || badFmt || badLit || badPc;
  assign spFault = baseIsSp && (baseLow != '0);
  assign wbEn    = isWb && !illegal && !spFault;
endmodule

// File: rtl/lsu_agu_datapath.sv
module lsu_agu_datapath
  import lsu_agu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 12,
  parameter int EXT_W  = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  immRaw,
  input  logic [ADDR_W-1:0] index,
  input  aguStrobeT         strobe,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] sum
);
  localparam int S7_W  = 7;
  localparam int S9_W  = 9;
  localparam int U12_W = 12;

  logic [ADDR_W-1:0] immVal;
  logic [ADDR_W-1:0] idxVal;
  logic [ADDR_W-1:0] offRaw;
  logic [ADDR_W-1:0] offScaled;

  always_comb begin
    unique case (strobe.fmt)
      FMT_S7:  immVal = {{(ADDR_W-S7_W){immRaw[S7_W-1]}}, immRaw[S7_W-1:0]};
      FMT_S9:  immVal = {{(ADDR_W-S9_W){immRaw[S9_W-1]}}, immRaw[S9_W-1:0]};
      FMT_U12: immVal = {{(ADDR_W-U12_W){1'b0}}, immRaw[U12_W-1:0]};
      default: immVal = '0;
    endcase
  end

  always_comb begin
    if (strobe.idxWide) begin
      idxVal = index;
    end else begin
      idxVal = {{(ADDR_W-EXT_W){strobe.extSigned & index[EXT_W-1]}}, index[EXT_W-1:0]};
    end
  end

  always_comb begin
    if (strobe.useImm)      offRaw = immVal;
    else if (strobe.useIdx) offRaw = idxVal;
    else                    offRaw = '0;
  end

  assign offScaled = offRaw << strobe.shiftAmt;
  assign sum       = base + offScaled;
  assign addr      = strobe.addrFromBase ? base : sum;
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_agu_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int IMM_W      = 12,
  parameter int EXT_W      = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              baseIsSp,
  input  logic              baseIsPc,
  input  logic [1:0]        offSrc,
  input  logic [1:0]        idxMode,
  input  logic [1:0]        immFmt,
  input  logic [IMM_W-1:0]  immRaw,
  input  logic [ADDR_W-1:0] index,
  input  logic              scaleEn,
  input  logic              extSigned,
  input  logic [1:0]        sizeLog2,
  output logic [ADDR_W-1:0] addr,
  output logic              wbEn,
  output logic [ADDR_W-1:0] wbVal,
  output logic              spFault,
  output logic              illegal
);
  aguStrobeT strobe;

  lsu_agu_ctrl #(.ALIGN_BITS(ALIGN_BITS)) uCtrl (
    .baseLow  (base[ALIGN_BITS-1:0]),
    .baseIsSp (baseIsSp),
    .baseIsPc (baseIsPc),
    .offSrc   (offSrcE'(offSrc)),
    .idxMode  (idxModeE'(idxMode)),
    .immFmt   (immFmtE'(immFmt)),
    .scaleEn  (scaleEn),
    .extSigned(extSigned),
    .sizeLog2 (sizeLog2),
    .strobe   (strobe),
    .wbEn     (wbEn),
    .spFault  (spFault),
    .illegal  (illegal)
  );

  lsu_agu_datapath #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .EXT_W(EXT_W)) uDp (
    .base  (base),
    .immRaw(immRaw),
    .index (index),
    .strobe(strobe),
    .addr  (addr),
    .sum   (wbVal)
  );
endmodule

// File: rtl/lsu_addr_gen_chk.sv
module lsu_addr_gen_chk #(
  parameter int ADDR_W = 64
) (
  input logic [ADDR_W-1:0] base,
  input logic              baseIsSp,
  input logic              baseIsPc,
  input logic [1:0]        offSrc,
  input logic [1:0]        idxMode,
  input logic [ADDR_W-1:0] addr,
  input logic              wbEn,
  input logic [ADDR_W-1:0] wbVal,
  input logic              spFault,
  input logic              illegal
);
  always_comb begin
    if (offSrc == 2'd0 && idxMode == 2'd0)
      AST_NO_OFFSET_BASE: assert (addr == base) else $error("no-offset address differs from base"); // R1
    if (idxMode == 2'd1)
      AST_PRE_ADDR_WB: assert (addr == wbVal) else $error("pre-index address differs from writeback"); // R3
    if (idxMode == 2'd2)
      AST_POST_ADDR_BASE: assert (addr == base) else $error("post-index address differs from base"); // R4
    if (baseIsPc && idxMode != 2'd3)
      AST_PC_NEEDS_LIT: assert (illegal) else $error("PC base outside literal not flagged"); // R9
    if (baseIsSp && base[3:0] != 4'd0)
      AST_SP_MISALIGN: assert (spFault) else $error("misaligned SP not flagged"); // R10
    if (!baseIsSp)
      AST_SP_ONLY: assert (!spFault) else $error("fault without SP base"); // R10
    if (wbEn)
      AST_WB_GATED: assert (!spFault && !illegal && (idxMode == 2'd1 || idxMode == 2'd2))
        else $error("writeback enabled when not allowed"); // R11
  end
endmodule

bind lsu_addr_gen lsu_addr_gen_chk #(.ADDR_W(ADDR_W)) uChk (
  .base    (base),
  .baseIsSp(baseIsSp),
  .baseIsPc(baseIsPc),
  .offSrc  (offSrc),
  .idxMode (idxMode),
  .addr    (addr),
  .wbEn    (wbEn),
  .wbVal   (wbVal),
  .spFault (spFault),
  .illegal (illegal)
);

// File: tb/sim_lsu_addr_gen.sv
`timescale 1ns/1ps
module sim_lsu_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] base = '0;
  logic        baseIsSp = 1'b0;
  logic        baseIsPc = 1'b0;
  logic [1:0]  offSrc = '0;
  logic [1:0]  idxMode = '0;
  logic [1:0]  immFmt = '0;
  logic [11:0] immRaw = '0;
  logic [63:0] index = '0;
  logic        scaleEn = 1'b0;
  logic        extSigned = 1'b0;
  logic [1:0]  sizeLog2 = '0;
  logic [63:0] addr;
  logic        wbEn;
  logic [63:0] wbVal;
  logic        spFault;
  logic        illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  lsu_addr_gen u0 (
    .base(base), .baseIsSp(baseIsSp), .baseIsPc(baseIsPc), .offSrc(offSrc),
    .idxMode(idxMode), .immFmt(immFmt), .immRaw(immRaw), .index(index),
    .scaleEn(scaleEn), .extSigned(extSigned), .sizeLog2(sizeLog2),
    .addr(addr), .wbEn(wbEn), .wbVal(wbVal), .spFault(spFault), .illegal(illegal)
  );

  // behavioural reference values
  logic [63:0] eAddr, eWbVal;
  logic        eWbEn, eFault, eIll;

  task automatic model();
    longint off;
    longint sh;
    bit wbMode;
    off = 0;
    sh  = 0;
    if (offSrc == 2'd1) begin
      if (immFmt == 2'd0)      begin off = longint'($signed(immRaw[6:0])); sh = sizeLog2; end
      else if (immFmt == 2'd1) begin off = longint'($signed(immRaw[8:0])); sh = 0; end
      else if (immFmt == 2'd2) begin off = longint'({20'd0, immRaw});      sh = sizeLog2; end
      else off = 0;
      if (idxMode == 2'd3) sh = 2;
    end else if (offSrc == 2'd2) begin
      off = longint'(index);
      sh  = scaleEn ? sizeLog2 : 0;
    end else if (offSrc == 2'd3) begin
      if (extSigned) off = longint'($signed(index[31:0]));
      else           off = longint'({32'd0, index[31:0]});
      sh = scaleEn ? sizeLog2 : 0;
    end
    if (idxMode == 2'd3 && offSrc != 2'd1) sh = 2;
    off    = off * (longint'(1) << sh);
    eWbVal = base + 64'(off);
    eAddr  = (idxMode == 2'd2) ? base : eWbVal;
    wbMode = (idxMode == 2'd1) || (idxMode == 2'd2);
    eIll   = 1'b0;
    if (wbMode && offSrc != 2'd1) eIll = 1'b1;
    if (wbMode && immFmt == 2'd2) eIll = 1'b1;
    if (offSrc == 2'd1 && immFmt == 2'd3) eIll = 1'b1;
    if (idxMode == 2'd3 && (offSrc != 2'd1 || sizeLog2 <= 2'd1 || !baseIsPc)) eIll = 1'b1;
    if (baseIsPc && idxMode != 2'd3) eIll = 1'b1;
    eFault = baseIsSp && (base % 16 != 0);
    eWbEn  = wbMode && !eIll && !eFault;
  endtask

  task automatic check(input string tag);
    model();
    checks++;
    if (addr !== eAddr || wbEn !== eWbEn || wbVal !== eWbVal || spFault !== eFault || illegal !== eIll) begin
      failures++;
      $display("FAIL %s: addr=%h wbEn=%0b wbVal=%h fault=%0b ill=%0b expected addr=%h wbEn=%0b wbVal=%h fault=%0b ill=%0b",
               tag, addr, wbEn, wbVal, spFault, illegal, eAddr, eWbEn, eWbVal, eFault, eIll);
    end
  endtask

  task automatic apply(input logic [63:0] b, input logic sp, input logic pc,
                       input logic [1:0] src, input logic [1:0] im, input logic [1:0] fmt,
                       input logic [11:0] raw, input logic [63:0] ix, input logic sc,
                       input logic sx, input logic [1:0] sz, input string tag);
    @(negedge clk);
    base = b; baseIsSp = sp; baseIsPc = pc; offSrc = src; idxMode = im; immFmt = fmt;
    immRaw = raw; index = ix; scaleEn = sc; extSigned = sx; sizeLog2 = sz;
    #(CLK_PERIOD/4);
    check(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset-state vector: all inputs zero
    @(negedge clk); #(CLK_PERIOD/4); check("R1 idle");
    apply(64'h1000_0000_0000_0010, 1, 0, 0, 0, 0, 12'h000, 64'h55, 0, 0, 3, "R1 exclusive SP");
    apply(64'h100, 0, 0, 1, 0, 0, 12'h07F, 0, 0, 0, 3, "R2 s7 -1 x8");
    apply(64'h100, 0, 0, 1, 0, 1, 12'h1F0, 0, 0, 0, 3, "R2 s9 -16 unscaled");
    apply(64'h100, 0, 0, 1, 0, 2, 12'hFFF, 0, 0, 0, 2, "R2 u12 4095 x4");
    apply(64'h7000, 1, 0, 1, 1, 1, 12'h020, 0, 0, 0, 3, "R3 pre SP +32");
    apply(64'h7000, 1, 0, 1, 2, 0, 12'h002, 0, 0, 0, 3, "R4 post s7 +16");
    apply(64'h2000, 0, 0, 2, 0, 0, 12'h000, 64'h5, 1, 0, 3, "R5 reg scaled");
    apply(64'h2000, 0, 0, 2, 0, 0, 12'h000, 64'h5, 0, 0, 3, "R5 reg unscaled");
    apply(64'h2000, 0, 0, 3, 0, 0, 12'h000, 64'hABCD_0000_FFFF_FFFF, 1, 1, 2, "R6 ext signed");
    apply(64'h2000, 0, 0, 3, 0, 0, 12'h000, 64'hABCD_0000_FFFF_FFFF, 1, 0, 2, "R6 ext zero");
    apply(64'h8000, 0, 1, 1, 3, 1, 12'h1FF, 0, 0, 0, 2, "R7 literal -1 x4");
    apply(64'h8000, 0, 1, 1, 3, 0, 12'h003, 0, 0, 0, 3, "R7 literal ignores size");
    apply(64'h8000, 0, 1, 1, 3, 1, 12'h004, 0, 0, 0, 1, "R7 literal halfword illegal");
    apply(64'h3000, 0, 0, 2, 1, 0, 12'h000, 64'h8, 0, 0, 3, "R8 pre with register");
    apply(64'h3000, 0, 0, 1, 2, 2, 12'h010, 0, 0, 0, 3, "R8 post with u12");
    apply(64'h3000, 0, 0, 1, 0, 3, 12'h010, 0, 0, 0, 3, "R8 reserved format");
    apply(64'h3000, 0, 0, 2, 3, 1, 12'h000, 64'h8, 0, 0, 3, "R8 literal with register");
    apply(64'h3000, 0, 1, 1, 0, 1, 12'h010, 0, 0, 0, 3, "R9 PC base offset mode");
    apply(64'h3000, 0, 0, 1, 3, 1, 12'h010, 0, 0, 0, 3, "R9 literal without PC");
    apply(64'h7008, 1, 0, 1, 1, 1, 12'h008, 0, 0, 0, 3, "R10 R11 pre on misaligned SP");
    apply(64'h7008, 1, 0, 1, 2, 1, 12'h008, 0, 0, 0, 3, "R10 R11 post on misaligned SP");
    apply(64'h7008, 1, 0, 3, 1, 0, 12'h000, 64'h1, 0, 0, 3, "R10 R8 fault and illegal together");
    apply(64'h7008, 0, 0, 1, 1, 1, 12'h008, 0, 0, 0, 3, "R10 non-SP misaligned");
    apply(64'h1234, 0, 0, 1, 0, 1, 12'h010, 0, 0, 0, 3, "R11 offset mode no wb");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, 1, 1, 12'h001, 0, 0, 0, 0, "R12 wrap up");
    apply(64'h0, 0, 0, 2, 0, 0, 12'h000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 3, "R12 wrap down");
    for (int i = 0; i < 600; i++) begin
      apply({$urandom, $urandom}, 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
            2'($urandom), 12'($urandom), {$urandom, $urandom}, 1'($urandom), 1'($urandom),
            2'($urandom), "R2-R12 random mix");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule